// File: doc/BRIEF.md
# Ringlet Node Link Controller

This block sits where a ringlet's input link meets the next hop of the ring. Symbols arrive one per clock on a 16-bit input, with a valid qualifier and a framing flag. The controller reads the first symbol of each packet as the target node identifier. Packets addressed to this node are placed in a receive queue for local logic. Every other packet goes into a bypass queue and is forwarded unchanged on the output link toward the next node.

Local logic queues its own outgoing packets in a transmit queue. The output merger always serves forwarded ring traffic first. A local packet is released only when the bypass queue is completely empty and only after the whole packet has been written. Once a packet has started on the output, it finishes before any other packet begins. When nothing is ready, the output carries idle symbols.

If a packet for this node finds too little room in the receive queue for a packet of the maximum length, the whole packet is discarded and a sticky overflow indicator is raised.

Top module: `ring_node`

## Requirements
- R1: After reset the output link is idle (`out_valid`, `out_flag` and `out_data` all zero), `rx_valid` is 0, `tx_ready` is 1 and `rx_overflow` is 0.
- R2: A packet starts on a valid symbol with the flag at 1 while no packet is open. It ends on the next valid symbol with the flag at 0, which is its trailer. Valid symbols with the flag at 0 outside a packet, and cycles with `in_valid` at 0, are discarded.
- R3: A packet whose first symbol equals `node_id` is delivered whole and in order on the receive port, with `rx_last` set only on its trailer. The receive port is show-ahead: a symbol is consumed in a cycle where `rx_valid` and `rx_ready` are both 1.
- R4: Any other packet leaves on the output link with the same symbols, in the same order. The flag is 1 on every symbol except the last, and the first output symbol appears two clock edges after it was driven on the input, provided the output is free.
- R5: A local packet may begin on the output only in a cycle where the bypass queue is empty and no forwarded packet is still in progress. Otherwise queued bypass symbols go first.
- R6: Symbols of two packets are never interleaved. A local packet, once started, leaves on consecutive cycles.
- R7: A local packet becomes eligible only once its symbol marked by `tx_last` has been accepted. `tx_ready` is 0 exactly when the transmit queue is full.
- R8: A packet for this node whose header arrives while the receive queue has fewer than `MAX_PKT` free entries is discarded entirely and sets `rx_overflow`, which stays 1 until reset. Later packets are handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | SYM_W | Identifier of this node |
| in_valid | input | 1 | Input symbol present |
| in_flag | input | 1 | Framing flag: 1 on all packet symbols except the trailer |
| in_data | input | SYM_W | Input symbol |
| out_valid | output | 1 | Output symbol present (0 means idle symbol) |
| out_flag | output | 1 | Framing flag on the output link |
| out_data | output | SYM_W | Output symbol, zero when idle |
| tx_valid | input | 1 | Local symbol offered |
| tx_data | input | SYM_W | Local symbol |
| tx_last | input | 1 | Marks the final symbol of a local packet |
| tx_ready | output | 1 | Transmit queue can accept a symbol |
| rx_valid | output | 1 | Received symbol available |
| rx_data | output | SYM_W | Received symbol |
| rx_last | output | 1 | Received symbol is a packet trailer |
| rx_ready | input | 1 | Local logic consumes the received symbol |
| rx_overflow | output | 1 | Sticky: a packet for this node was discarded |

## Verification
The assertions assume that input packets have between 2 and `MAX_PKT` symbols and that local packets are no longer than `MAX_PKT`. They also assume that the arriving ring traffic leaves enough idle time for the bypass queue never to fill, and that local logic only presents a symbol when `tx_ready` is high. The stimulus keeps packet lengths within these limits and puts idle gaps between ring packets, so that the bypass backlog stays under one queue depth even while a local packet is draining. It offers transmit symbols only after seeing `tx_ready`, and stalls `rx_ready` on purpose to reach the discard case.

// File: rtl/ring_pkg.sv
package ring_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BYP  = 2'd1,
    SRC_LOC  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    RT_BYP  = 2'd0,
    RT_RX   = 2'd1,
    RT_DROP = 2'd2
  } route_e;

  function automatic int unsigned room_left(int unsigned depth, int unsigned used);
    return depth - used;
  endfunction

  function automatic logic starts_packet(logic v, logic f, logic open_pkt);
    return v & f & ~open_pkt;
  endfunction

  function automatic logic ends_packet(logic v, logic f, logic open_pkt);
    return v & ~f & open_pkt;
  endfunction

endpackage

// File: rtl/ring_fifo.sv
module ring_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign wr_ok   = wr_en & ~full;
  assign rd_ok   = rd_en & ~empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty); // R6

endmodule

// File: rtl/ring_rx_router.sv
module ring_rx_router
  import ring_pkg::*;
#(
  parameter int SYM_W    = 16,
  parameter int MAX_PKT  = 16,
  parameter int RX_DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_flag,
  input  logic [SYM_W-1:0]              in_data,
  input  logic [SYM_W-1:0]              node_id,
  input  logic [$clog2(RX_DEPTH+1)-1:0] rx_count,
  output logic                          byp_wr,
  output logic                          rx_wr,
  output logic [SYM_W:0]                wr_sym,
  output logic                          drop_start,
  output logic                          ovf
);
  logic   open_q;
  route_e route_q, route_now;
  logic   hdr, tail, accept, is_mine, room_ok;

  assign hdr     = starts_packet(in_valid, in_flag, open_q);
  assign tail    = ends_packet(in_valid, in_flag, open_q);
  assign accept  = hdr | (in_valid & open_q);
  assign is_mine = (in_data == node_id);
  assign room_ok = room_left(RX_DEPTH, 32'(rx_count)) >= 32'(MAX_PKT);

  always_comb begin
    route_now = route_q;
    if (hdr) begin
      if (!is_mine)     route_now = RT_BYP;
      else if (room_ok) route_now = RT_RX;
      else              route_now = RT_DROP;
    end
  end

  assign byp_wr     = accept & (route_now == RT_BYP);
  assign rx_wr      = accept & (route_now == RT_RX);
  assign wr_sym     = {tail, in_data};
  assign drop_start = hdr & (route_now == RT_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      route_q <= RT_BYP;
      ovf     <= 1'b0;
    end else begin
      if (hdr) begin
        open_q  <= 1'b1;
        route_q <= route_now;
      end else if (tail) begin
        open_q  <= 1'b0;
      end
      if (drop_start) ovf <= 1'b1;
    end
  end

  AST_DROP_RAISES_OVF:  assert property (@(posedge clk) disable iff (!rst_n) drop_start |=> ovf); // R8
  AST_OVF_STICKY:       assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf); // R8
  AST_FOREIGN_NOT_RX:   assert property (@(posedge clk) disable iff (!rst_n) (hdr && in_data != node_id) |-> !rx_wr); // R4
  AST_STRAY_DISCARDED:  assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_flag && !open_q) |-> !(byp_wr || rx_wr)); // R2

endmodule

// File: rtl/ring_out_arb.sv
module ring_out_arb
  import ring_pkg::*;
#(
  parameter int SYM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byp_empty,
  input  logic [SYM_W:0]   byp_sym,
  input  logic             tx_has_pkt,
  input  logic [SYM_W:0]   tx_sym,
  output logic             byp_pop,
  output logic             tx_pop,
  output logic             loc_start,
  output logic             out_valid,
  output logic             out_flag,
  output logic [SYM_W-1:0] out_data
);
  src_e           cur_q, sel;
  logic [SYM_W:0] sym;
  logic           popped, last;

  always_comb begin
    sel = cur_q;
    if (cur_q == SRC_NONE) begin
      if (!byp_empty)      sel = SRC_BYP;
      else if (tx_has_pkt) sel = SRC_LOC;
    end
  end

  assign byp_pop   = (sel == SRC_BYP) & ~byp_empty;
  assign tx_pop    = (sel == SRC_LOC);
  assign popped    = byp_pop | tx_pop;
  assign sym       = byp_pop ? byp_sym : tx_sym;
  assign last      = sym[SYM_W];
  assign loc_start = tx_pop & (cur_q == SRC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= SRC_NONE;
      out_valid <= 1'b0;
      out_flag  <= 1'b0;
      out_data  <= '0;
    end else begin
      if (popped) cur_q <= last ? SRC_NONE : sel;
      out_valid <= popped;
      out_flag  <= popped & ~last;
      out_data  <= popped ? sym[SYM_W-1:0] : '0;
    end
  end

  AST_LOCAL_AFTER_BYP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) loc_start |-> byp_empty); // R5
  AST_LOCAL_NO_GAP:          assert property (@(posedge clk) disable iff (!rst_n) (cur_q == SRC_LOC) |-> tx_pop); // R6
  AST_BYP_NOT_MIXED:         assert property (@(posedge clk) disable iff (!rst_n) (cur_q == SRC_BYP) |-> !tx_pop); // R6
  AST_LOCAL_WHOLE:           assert property (@(posedge clk) disable iff (!rst_n) loc_start |-> tx_has_pkt); // R7

endmodule

// File: rtl/ring_node.sv
module ring_node #(
  parameter int SYM_W     = 16,
  parameter int MAX_PKT   = 16,
  parameter int RX_DEPTH  = 32,
  parameter int TX_DEPTH  = 32,
  parameter int BYP_DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] node_id,
  input  logic             in_valid,
  input  logic             in_flag,
  input  logic [SYM_W-1:0] in_data,
  output logic             out_valid,
  output logic             out_flag,
  output logic [SYM_W-1:0] out_data,
  input  logic             tx_valid,
  input  logic [SYM_W-1:0] tx_data,
  input  logic             tx_last,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [SYM_W-1:0] rx_data,
  output logic             rx_last,
  input  logic             rx_ready,
  output logic             rx_overflow
);
  localparam int RX_CW  = $clog2(RX_DEPTH + 1);
  localparam int TX_CW  = $clog2(TX_DEPTH + 1);
  localparam int BYP_CW = $clog2(BYP_DEPTH + 1);

  logic [RX_CW-1:0]  rx_cnt;
  logic [TX_CW-1:0]  tx_cnt, tx_pkts;
  logic [BYP_CW-1:0] byp_cnt;
  logic [SYM_W:0]    in_sym, byp_sym, tx_sym, rx_sym;
  logic              byp_wr, rx_wr, byp_pop, tx_pop, tx_push, rx_pop;
  logic              drop_start, loc_start, byp_empty;
  logic              pkt_in, pkt_out;

  ring_rx_router #(.SYM_W(SYM_W), .MAX_PKT(MAX_PKT), .RX_DEPTH(RX_DEPTH)) u_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flag(in_flag), .in_data(in_data),
    .node_id(node_id), .rx_count(rx_cnt), .byp_wr(byp_wr), .rx_wr(rx_wr), .wr_sym(in_sym),
    .drop_start(drop_start), .ovf(rx_overflow)
  );

  ring_fifo #(.W(SYM_W + 1), .DEPTH(BYP_DEPTH)) u_byp_q (
    .clk(clk), .rst_n(rst_n), .wr_en(byp_wr), .wr_data(in_sym),
    .rd_en(byp_pop), .rd_data(byp_sym), .count(byp_cnt)
  );

  ring_fifo #(.W(SYM_W + 1), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .wr_en(rx_wr), .wr_data(in_sym),
    .rd_en(rx_pop), .rd_data(rx_sym), .count(rx_cnt)
  );

  ring_fifo #(.W(SYM_W + 1), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .wr_en(tx_push), .wr_data({tx_last, tx_data}),
    .rd_en(tx_pop), .rd_data(tx_sym), .count(tx_cnt)
  );

  assign byp_empty = (byp_cnt == '0);
  assign tx_ready  = (tx_cnt != TX_CW'(TX_DEPTH));
  assign tx_push   = tx_valid & tx_ready;
  assign rx_valid  = (rx_cnt != '0);
  assign rx_pop    = rx_valid & rx_ready;
  assign rx_data   = rx_sym[SYM_W-1:0];
  assign rx_last   = rx_sym[SYM_W];
  assign pkt_in    = tx_push & tx_last;
  assign pkt_out   = tx_pop & tx_sym[SYM_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_pkts <= '0;
    else begin
      case ({pkt_in, pkt_out})
        2'b10:   tx_pkts <= tx_pkts + 1'b1;
        2'b01:   tx_pkts <= tx_pkts - 1'b1;
        default: tx_pkts <= tx_pkts;
      endcase
    end
  end

  ring_out_arb #(.SYM_W(SYM_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .byp_empty(byp_empty), .byp_sym(byp_sym),
    .tx_has_pkt(tx_pkts != '0), .tx_sym(tx_sym), .byp_pop(byp_pop), .tx_pop(tx_pop),
    .loc_start(loc_start), .out_valid(out_valid), .out_flag(out_flag), .out_data(out_data)
  );

  AST_BYP_NO_OVERRUN:  assert property (@(posedge clk) disable iff (!rst_n) byp_wr |-> (byp_cnt != BYP_CW'(BYP_DEPTH))); // R4
  AST_TX_PKTS_FIT:     assert property (@(posedge clk) disable iff (!rst_n) tx_pkts <= tx_cnt); // R7
  AST_DROP_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n) drop_start |-> !(rx_wr || byp_wr)); // R8
  AST_LOCAL_START_1:   assert property (@(posedge clk) disable iff (!rst_n) loc_start |-> tx_cnt != '0); // R5

endmodule

// File: tb/sim_ring_node.sv
module sim_ring_node;
  localparam int SYM_W = 16, MAX_PKT = 16, RX_DEPTH = 32, TX_DEPTH = 32, BYP_DEPTH = 32;
  localparam logic [15:0] MY_ID = 16'h0042;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_flag = 0, tx_valid = 0, tx_last = 0, rx_ready = 0;
  logic [15:0] in_data = '0, tx_data = '0;
  logic out_valid, out_flag, tx_ready, rx_valid, rx_last, rx_overflow;
  logic [15:0] out_data, rx_data;
  bit rand_rx = 0;

  always #10 clk = ~clk;

  ring_node #(.SYM_W(SYM_W), .MAX_PKT(MAX_PKT), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH),
              .BYP_DEPTH(BYP_DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .node_id(MY_ID), .in_valid(in_valid), .in_flag(in_flag),
    .in_data(in_data), .out_valid(out_valid), .out_flag(out_flag), .out_data(out_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .rx_overflow(rx_overflow)
  );

  int checks = 0, errors = 0, rx_pkts_seen = 0, out_pkts_seen = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [16:0] byp_q[$], tx_q[$], rx_q[$];
  int m_cur = 0, m_src = 0, m_tx_pkts = 0, m_route = 0;
  bit m_start = 0, m_open = 0, m_ovf = 0, m_ov = 0, m_of = 0;
  logic [15:0] m_od = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      byp_q.delete(); tx_q.delete(); rx_q.delete();
      m_cur = 0; m_src = 0; m_tx_pkts = 0; m_open = 0; m_ovf = 0;
      m_ov = 0; m_of = 0; m_od = '0;
    end else begin
      int sel, free, txsz;
      logic [16:0] s;
      bit popped;
      txsz = tx_q.size();
      free = RX_DEPTH - rx_q.size();
      popped = 0; s = '0;
      sel = m_cur;
      if (sel == 0) sel = (byp_q.size() > 0) ? 1 : ((m_tx_pkts > 0) ? 2 : 0);
      m_start = (m_cur == 0);
      if (sel == 1 && byp_q.size() > 0) begin s = byp_q.pop_front(); popped = 1; end
      else if (sel == 2) begin s = tx_q.pop_front(); popped = 1; if (s[16]) m_tx_pkts--; end
      m_ov = popped; m_of = popped && !s[16]; m_od = popped ? s[15:0] : '0;
      m_src = popped ? sel : 0;
      if (popped) m_cur = s[16] ? 0 : sel;
      if (rx_ready && rx_q.size() > 0) begin
        void'(rx_q.pop_front());
      end
      if (in_valid) begin
        bit wr, lst;
        wr = 0; lst = 0;
        if (!m_open && in_flag) begin
          m_route = (in_data != MY_ID) ? 0 : ((free >= MAX_PKT) ? 1 : 2);
          if (m_route == 2) m_ovf = 1;
          m_open = 1; wr = 1;
        end else if (m_open) begin
          wr = 1; lst = !in_flag;
          if (lst) m_open = 0;
        end
        if (wr && m_route == 0) byp_q.push_back({lst, in_data});
        if (wr && m_route == 1) rx_q.push_back({lst, in_data});
      end
      if (tx_valid && txsz < TX_DEPTH) begin
        tx_q.push_back({tx_last, tx_data});
        if (tx_last) m_tx_pkts++;
      end
    end
  end

  always @(posedge clk) if (rst_n && rx_valid && rx_ready && rx_last) rx_pkts_seen++;

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string oreq;
      oreq = (m_src == 2) ? (m_start ? "R5" : "R6") : ((m_src == 1) ? "R4" : "R5");
      check(oreq, "out_valid", out_valid, m_ov);
      check(oreq, "out_flag", out_flag, m_of);
      check(oreq, "out_data", out_data, m_od);
      check("R3", "rx_valid", rx_valid, rx_q.size() > 0);
      if (rx_q.size() > 0) check("R3", "rx_sym", {rx_last, rx_data}, rx_q[0]);
      check("R7", "tx_ready", tx_ready, tx_q.size() < TX_DEPTH);
      check("R8", "rx_overflow", rx_overflow, m_ovf);
      if (out_valid && !out_flag) out_pkts_seen++;
    end
  end

  always @(negedge clk) if (rand_rx) rx_ready = ($urandom % 4) != 0;

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic in_pkt(logic [15:0] id, int len, bit gap);
    for (int i = 0; i < len; i++) begin
      if (gap && i == len / 2) begin
        @(negedge clk); in_valid = 0; in_flag = 1; in_data = 16'hdead;
      end
      @(negedge clk);
      in_valid = 1; in_flag = (i != len - 1);
      in_data = (i == 0) ? id : {id[7:0], 8'(i)};
    end
    @(negedge clk); in_valid = 0; in_flag = 0; in_data = '0;
  endtask

  task automatic tx_pkt(logic [15:0] tag, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      tx_valid = 0;
      while (!tx_ready) @(negedge clk);
      tx_valid = 1; tx_last = (i == len - 1); tx_data = {tag[7:0], 8'(i)};
    end
    @(negedge clk); tx_valid = 0; tx_last = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    idle(3);
    check("R1", "out_valid", out_valid, 0);
    check("R1", "out_flag", out_flag, 0);
    check("R1", "out_data", out_data, 0);
    check("R1", "rx_valid", rx_valid, 0);
    check("R1", "tx_ready", tx_ready, 1);
    check("R1", "rx_overflow", rx_overflow, 0);
    rst_n = 1; rx_ready = 1;

    // R2: stray trailer-like symbols and flagged invalid cycles are discarded
    repeat (3) begin @(negedge clk); in_valid = 1; in_flag = 0; in_data = MY_ID; end
    repeat (2) begin @(negedge clk); in_valid = 0; in_flag = 1; in_data = 16'h0007; end
    @(negedge clk); in_valid = 0; in_flag = 0; in_data = '0;
    idle(4);
    check("R2", "rx_valid after stray", rx_valid, 0);
    check("R2", "out packets after stray", out_pkts_seen, 0);

    // R3: packet for this node reaches the receive port
    in_pkt(MY_ID, 5, 0);
    idle(8);
    check("R3", "rx packets", rx_pkts_seen, 1);

    // R4: foreign packets forwarded, one with an input gap
    in_pkt(16'h0007, 6, 0);
    in_pkt(16'h0099, MAX_PKT, 1);
    idle(30);
    check("R4", "forwarded packets", out_pkts_seen, 2);

    // R7: partially written local packet must not start
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tx_valid = 1; tx_last = 0; tx_data = 16'h5100 + 16'(i);
    end
    @(negedge clk); tx_valid = 0;
    repeat (6) begin @(negedge clk); check("R7", "out_valid while incomplete", out_valid, 0); end
    @(negedge clk); tx_valid = 1; tx_last = 1; tx_data = 16'h51ff;
    @(negedge clk); tx_valid = 0; tx_last = 0;
    idle(20);

    // R5/R6: contention between ring traffic and local packets
    fork
      begin
        for (int k = 0; k < 6; k++) begin in_pkt(16'h0100 + 16'(k), 4 + 2 * k, k[0]); idle(3); end
      end
      begin
        for (int k = 0; k < 4; k++) tx_pkt(16'h00a0 + 16'(k), 3 + 3 * k);
      end
    join
    idle(80);

    // R8: receive queue too full for a third maximum-length packet
    rx_ready = 0;
    base = rx_pkts_seen;
    for (int k = 0; k < 3; k++) in_pkt(MY_ID, MAX_PKT, 0);
    idle(4);
    check("R8", "overflow raised", rx_overflow, 1);
    rx_ready = 1;
    idle(60);
    check("R8", "packets kept", rx_pkts_seen - base, 2);
    in_pkt(MY_ID, 4, 0);
    idle(10);
    check("R8", "later packet delivered", rx_pkts_seen - base, 3);

    // mixed traffic with a stalling receiver
    rand_rx = 1;
    fork
      begin
        for (int k = 0; k < 30; k++) begin
          in_pkt(($urandom % 3 == 0) ? MY_ID : 16'(16'h0200 + k), 2 + ($urandom % (MAX_PKT - 1)), k[1]);
          idle(2 + ($urandom % 4));
        end
      end
      begin
        for (int k = 0; k < 10; k++) tx_pkt(16'h00c0 + 16'(k), 1 + ($urandom % MAX_PKT));
      end
    join
    rand_rx = 0;
    @(negedge clk); rx_ready = 1;
    idle(200);
    check("R3", "receive drained", rx_valid, 0);
    check("R4", "output idle at end", out_valid, 0);
    finish_run();
  end

endmodule